// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block performs the entry sequence of an 8-bit processor core when control leaves normal instruction flow: a cold reset, a non-maskable interrupt (NMI) or a maskable interrupt (IRQ). The execution unit pulses `start` between instructions and hands over the current program counter, stack pointer, status byte and the interrupt-disable flag as it stood before the instruction that just finished. The sequencer decides whether an entry happens. If one does, it writes the return address and a stacked status byte into page 1 of memory, reads the 16-bit vector low byte first, and returns the new program counter, stack pointer and status together with the cycle cost of the entry.

Requests are held inside the block. The maskable request is the OR of a parameterised set of level sources, each with its own set and clear pulse, and one temporary source. NMI and the temporary source are one-shot: they are dropped by every evaluation, whether or not an entry was made. A `boot` pulse runs the reset sequence. A `jam_set` pulse marks the core as jammed. A jammed core takes no interrupts until a reset sequence runs.

Top module: `intr_entry_seq`

## Requirements
- R1: After synchronous `rst`, all outputs are zero (`pc_out`, `sp_out`, `st_out`, `jammed`, `busy`, `done`, `entry_kind`, `entry_cycles`) and no request is pending: an evaluation with no new request returns kind none.
- R2: An NMI entry writes PC[15:8] to 0x0100+SP, then PC[7:0] to 0x0100+SP-1, then the stacked status to 0x0100+SP-2. The stacked status is the input status with bit 4 cleared and bit 5 set. The entry then reads 0xFFFA (low) and 0xFFFB (high). Results: `st_out` is the input status with bit 4 cleared and bit 2 unchanged, `sp_out` is SP-3, `entry_cycles` is 7 and `entry_kind` is 2.
- R3: An IRQ entry uses the same three pushes and reads its vector from 0xFFFE/0xFFFF. It returns `st_out` with bit 4 cleared and bit 2 (interrupt disable) set, `entry_cycles` 7 and `entry_kind` 3.
- R4: When both NMI and IRQ are pending, NMI is taken. NMI is taken even when `i_prev` is 1.
- R5: When `i_prev` is 1, a pending level IRQ is not taken. The evaluation returns kind 0 with `pc_out`, `sp_out` and `st_out` equal to the inputs and makes no memory write. The level request stays pending and is taken by a later evaluation with `i_prev` 0.
- R6: `jam_set` raises `jammed`. While `jammed` is 1, an evaluation takes neither NMI nor IRQ and returns kind 0.
- R7: `boot` reads 0xFFFC then 0xFFFD and makes no write. It returns `pc_out` equal to the vector, `st_out` 0x04, `sp_out` equal to `sp_in`, `entry_kind` 1 and `entry_cycles` 0, and it clears `jammed`. `boot` takes precedence over a simultaneous `start`.
- R8: Every evaluation drops a pending NMI and a pending temporary request, even when it makes no entry. Level sources stay pending until their own clear pulse.
- R9: A set pulse in the same cycle as the matching clear, or as an evaluation that would drop the request, leaves the request pending.
- R10: The stack pointer wraps within 8 bits. An entry with SP 0x00 writes 0x0100, then 0x01FF, then 0x01FE, and returns `sp_out` 0xFD.
- R11: `done` is a one-cycle pulse. It comes 6 clock edges after the accepting edge counts as edge 1 for an NMI/IRQ entry, 3 for a reset and 1 for no entry. `busy` is high in between, and a `start` seen while busy is ignored.
- R12: Level sources are independent. Clearing one leaves another pending and still taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| boot | input | 1 | Pulse: run the reset-vector sequence |
| start | input | 1 | Pulse: evaluate interrupts between instructions |
| i_prev | input | 1 | Interrupt-disable flag from before the last instruction |
| nmi_set | input | 1 | Pulse: raise a one-shot NMI request |
| temp_set | input | 1 | Pulse: raise the one-shot temporary maskable request |
| src_set | input | NSRC | Per-source set pulses for level maskable requests |
| src_clr | input | NSRC | Per-source clear pulses for level maskable requests |
| jam_set | input | 1 | Pulse: mark the core as jammed |
| pc_in | input | 16 | Program counter to stack |
| sp_in | input | 8 | Stack pointer before entry |
| st_in | input | 8 | Status byte before entry |
| mem_addr | output | 16 | Memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Memory read strobe (data returned in the same cycle) |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: results valid |
| entry_kind | output | 2 | 0 none, 1 reset, 2 NMI, 3 IRQ |
| entry_cycles | output | 4 | Cycle cost charged for the entry |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | New stack pointer |
| st_out | output | 8 | New status byte |
| jammed | output | 1 | Core jammed flag |

## Verification
Two functions can fall in the same cycle. One is a request arriving; the other is the evaluation that drops one-shot requests, or the clear pulse of a level source. The bench drives `nmi_set` on the same edge as `start`, with nothing pending, and expects that evaluation to return none and the next one to take the NMI. It also drives `src_set` and `src_clr` for one source together and expects a later unmasked evaluation to take the IRQ. A third collision is `start` arriving while an entry is still running: the bench expects exactly three pushes, carrying the first caller's program counter.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE;
    localparam logic [7:0]        STACK_PAGE = 8'h01;

    localparam int FLG_I = 2;
    localparam int FLG_B = 4;
    localparam int FLG_U = 5;

    typedef enum logic [1:0] {
        ENT_NONE  = 2'd0,
        ENT_RESET = 2'd1,
        ENT_NMI   = 2'd2,
        ENT_IRQ   = 2'd3
    } entry_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH_HI,
        SQ_PUSH_LO,
        SQ_PUSH_ST,
        SQ_VEC_LO,
        SQ_VEC_HI
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [7:0]        sp;
        logic [DATA_W-1:0] st;
    } ctx_t;

    function automatic logic [DATA_W-1:0] stacked_status(input logic [DATA_W-1:0] st);
        logic [DATA_W-1:0] r;
        r        = st;
        r[FLG_B] = 1'b0;
        r[FLG_U] = 1'b1;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vector_of(input entry_e k);
        case (k)
            ENT_NMI:   return VEC_NMI;
            ENT_IRQ:   return VEC_IRQ;
            default:   return VEC_RST;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] exit_status(input entry_e k, input logic [DATA_W-1:0] st);
        logic [DATA_W-1:0] r;
        r = st;
        case (k)
            ENT_RESET: begin
                r        = '0;
                r[FLG_I] = 1'b1;
            end
            ENT_NMI:   r[FLG_B] = 1'b0;
            ENT_IRQ: begin
                r[FLG_B] = 1'b0;
                r[FLG_I] = 1'b1;
            end
            default:   r = st;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/intr_pending.sv
module intr_pending #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic            temp_set,
    input  logic            nmi_set,
    input  logic            consume,
    output logic            nmi_pend,
    output logic            irq_pend
);
    logic [NSRC-1:0] lvl_q;
    logic            temp_q;
    logic            nmi_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)              lvl_q[g] <= 1'b0;
            else if (src_set[g])  lvl_q[g] <= 1'b1;
            else if (src_clr[g])  lvl_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= 1'b0;
            nmi_q  <= 1'b0;
        end else begin
            if (temp_set)     temp_q <= 1'b1;
            else if (consume) temp_q <= 1'b0;
            if (nmi_set)      nmi_q  <= 1'b1;
            else if (consume) nmi_q  <= 1'b0;
        end
    end

    assign nmi_pend = nmi_q;
    assign irq_pend = (|lvl_q) | temp_q;

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_seq_pkg::*;
(
    input  logic   boot,
    input  logic   start,
    input  logic   busy,
    input  logic   jammed,
    input  logic   nmi_pend,
    input  logic   irq_pend,
    input  logic   i_prev,
    output logic   accept,
    output logic   consume,
    output entry_e kind
);
    always_comb begin
        accept  = !busy && (boot || start);
        consume = !busy && start && !boot;
        if (boot)                      kind = ENT_RESET;
        else if (jammed)               kind = ENT_NONE;
        else if (nmi_pend)             kind = ENT_NMI;
        else if (irq_pend && !i_prev)  kind = ENT_IRQ;
        else                           kind = ENT_NONE;
    end

endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
#(
    parameter int COST   = 7,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  entry_e            kind,
    input  ctx_t              ctx_in,
    input  logic              jam_set,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              busy,
    output logic              jammed,
    output logic              done,
    output entry_e            kind_out,
    output logic [CYC_W-1:0]  cycles,
    output ctx_t              ctx_out
);
    seq_e              state;
    entry_e            kind_q;
    ctx_t              work;
    logic [DATA_W-1:0] vec_lo;
    logic [ADDR_W-1:0] vec_base;

    assign vec_base = vector_of(kind_q);
    assign busy     = (state != SQ_IDLE);

    always_comb begin
        mem_addr  = '0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        mem_rd    = 1'b0;
        case (state)
            SQ_PUSH_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, work.sp};
                mem_wdata = work.pc[15:8];
            end
            SQ_PUSH_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, work.sp};
                mem_wdata = work.pc[7:0];
            end
            SQ_PUSH_ST: begin
                mem_wr    = 1'b1;
                mem_addr  = {STACK_PAGE, work.sp};
                mem_wdata = stacked_status(work.st);
            end
            SQ_VEC_LO: begin
                mem_rd   = 1'b1;
                mem_addr = vec_base;
            end
            SQ_VEC_HI: begin
                mem_rd   = 1'b1;
                mem_addr = {vec_base[ADDR_W-1:1], 1'b1};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            kind_q   <= ENT_NONE;
            work     <= '0;
            vec_lo   <= '0;
            jammed   <= 1'b0;
            done     <= 1'b0;
            kind_out <= ENT_NONE;
            cycles   <= '0;
            ctx_out  <= '0;
        end else begin
            done <= 1'b0;
            if (jam_set) jammed <= 1'b1;
            case (state)
                SQ_IDLE: if (accept) begin
                    kind_q <= kind;
                    work   <= ctx_in;
                    if (kind == ENT_RESET) begin
                        jammed <= 1'b0;
                        state  <= SQ_VEC_LO;
                    end else if (kind == ENT_NONE) begin
                        done     <= 1'b1;
                        kind_out <= ENT_NONE;
                        cycles   <= '0;
                        ctx_out  <= ctx_in;
                    end else begin
                        state <= SQ_PUSH_HI;
                    end
                end
                SQ_PUSH_HI: begin
                    work.sp <= work.sp - 8'd1;
                    state   <= SQ_PUSH_LO;
                end
                SQ_PUSH_LO: begin
                    work.sp <= work.sp - 8'd1;
                    state   <= SQ_PUSH_ST;
                end
                SQ_PUSH_ST: begin
                    work.sp <= work.sp - 8'd1;
                    state   <= SQ_VEC_LO;
                end
                SQ_VEC_LO: begin
                    vec_lo <= mem_rdata;
                    state  <= SQ_VEC_HI;
                end
                SQ_VEC_HI: begin
                    ctx_out.pc <= {mem_rdata, vec_lo};
                    ctx_out.sp <= work.sp;
                    ctx_out.st <= exit_status(kind_q, work.st);
                    kind_out   <= kind_q;
                    cycles     <= (kind_q == ENT_RESET) ? '0 : CYC_W'(COST);
                    done       <= 1'b1;
                    state      <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int COST  = 7,
    parameter int CYC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot,
    input  logic              start,
    input  logic              i_prev,
    input  logic              nmi_set,
    input  logic              temp_set,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              jam_set,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        sp_in,
    input  logic [7:0]        st_in,
    output logic [15:0]       mem_addr,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        entry_kind,
    output logic [CYC_W-1:0]  entry_cycles,
    output logic [15:0]       pc_out,
    output logic [7:0]        sp_out,
    output logic [7:0]        st_out,
    output logic              jammed
);
    logic   nmi_pend, irq_pend, accept, consume;
    entry_e kind_sel, kind_done;
    ctx_t   ctx_in, ctx_res;

    assign ctx_in = '{pc: pc_in, sp: sp_in, st: st_in};

    intr_pending #(.NSRC(NSRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .src_set  (src_set),
        .src_clr  (src_clr),
        .temp_set (temp_set),
        .nmi_set  (nmi_set),
        .consume  (consume),
        .nmi_pend (nmi_pend),
        .irq_pend (irq_pend)
    );

    intr_arbiter u_arb (
        .boot     (boot),
        .start    (start),
        .busy     (busy),
        .jammed   (jammed),
        .nmi_pend (nmi_pend),
        .irq_pend (irq_pend),
        .i_prev   (i_prev),
        .accept   (accept),
        .consume  (consume),
        .kind     (kind_sel)
    );

    intr_seq_fsm #(.COST(COST), .CYC_W(CYC_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .kind      (kind_sel),
        .ctx_in    (ctx_in),
        .jam_set   (jam_set),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .busy      (busy),
        .jammed    (jammed),
        .done      (done),
        .kind_out  (kind_done),
        .cycles    (entry_cycles),
        .ctx_out   (ctx_res)
    );

    assign entry_kind = kind_done;
    assign pc_out     = ctx_res.pc;
    assign sp_out     = ctx_res.sp;
    assign st_out     = ctx_res.st;

endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
    parameter int CYC_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             boot,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             jammed,
    input logic             mem_wr,
    input logic             mem_rd,
    input logic [15:0]      mem_addr,
    input logic [1:0]       entry_kind,
    input logic [CYC_W-1:0] entry_cycles,
    input logic [7:0]       st_out
);
    // R11: results are announced for exactly one cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a sequence in progress ends before another can be accepted
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !(done && entry_kind == 2'd0));

    // R2 / R10: every push lands in page 1 and never overlaps a read
    assert_push_page_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr[15:8] == 8'h01 && !mem_rd));

    // R2: vector reads stay inside the top vector area
    assert_vec_area_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[15:3] == 13'h1FFF && mem_addr[2:0] >= 3'd2));

    // R2: an interrupt entry is charged seven cycles
    assert_cost_R2: assert property (@(posedge clk) disable iff (rst)
        (done && entry_kind[1]) |-> (entry_cycles == CYC_W'(7)));

    // R3: a maskable entry leaves interrupts disabled
    assert_irq_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (done && entry_kind == 2'd3) |-> st_out[2]);

    // R7: reset completion leaves only the disable flag and no jam
    assert_reset_state_R7: assert property (@(posedge clk) disable iff (rst)
        (done && entry_kind == 2'd1) |-> (st_out == 8'h04 && !jammed));

    // R6: a jammed core answers an evaluation with no entry
    assert_jam_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (jammed && start && !busy && !boot) |=> (!busy && done && entry_kind == 2'd0));

endmodule

bind intr_entry_seq intr_entry_seq_chk #(.CYC_W(CYC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .boot         (boot),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .jammed       (jammed),
    .mem_wr       (mem_wr),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr),
    .entry_kind   (entry_kind),
    .entry_cycles (entry_cycles),
    .st_out       (st_out)
);

// File: tb/intr_entry_seq_test.sv
module intr_entry_seq_test;
    localparam int NSRC = 4;

    logic            clk = 1'b0;
    logic            rst, boot, start, i_prev, nmi_set, temp_set, jam_set;
    logic [NSRC-1:0] src_set, src_clr;
    logic [15:0]     pc_in, mem_addr, pc_out;
    logic [7:0]      sp_in, st_in, mem_wdata, mem_rdata, sp_out, st_out;
    logic            mem_wr, mem_rd, busy, done, jammed;
    logic [1:0]      entry_kind;
    logic [3:0]      entry_cycles;

    int total = 0;
    int bad   = 0;

    logic [15:0] wa [64];
    logic [7:0]  wd [64];
    int          wn = 0;

    always #5 clk = ~clk;

    intr_entry_seq #(.NSRC(NSRC)) uut (
        .clk(clk), .rst(rst), .boot(boot), .start(start), .i_prev(i_prev),
        .nmi_set(nmi_set), .temp_set(temp_set), .src_set(src_set), .src_clr(src_clr),
        .jam_set(jam_set), .pc_in(pc_in), .sp_in(sp_in), .st_in(st_in),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .entry_kind(entry_kind),
        .entry_cycles(entry_cycles), .pc_out(pc_out), .sp_out(sp_out), .st_out(st_out),
        .jammed(jammed)
    );

    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h34;
            16'hFFFB: mem_rdata = 8'h12;
            16'hFFFC: mem_rdata = 8'hBC;
            16'hFFFD: mem_rdata = 8'h9A;
            16'hFFFE: mem_rdata = 8'h78;
            16'hFFFF: mem_rdata = 8'h56;
            default:  mem_rdata = 8'hEE;
        endcase
    end

    always @(posedge clk) begin
        if (mem_wr && wn < 64) begin
            wa[wn] <= mem_addr;
            wd[wn] <= mem_wdata;
            wn     <= wn + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic clear_pulses();
        start = 0; boot = 0; nmi_set = 0; temp_set = 0; jam_set = 0;
        src_set = '0; src_clr = '0;
    endtask

    task automatic pulse_src(input logic [NSRC-1:0] s, input logic [NSRC-1:0] c);
        @(negedge clk);
        src_set = s; src_clr = c;
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic pulse_misc(input bit nmi, input bit tmp, input bit jam);
        @(negedge clk);
        nmi_set = nmi; temp_set = tmp; jam_set = jam;
        @(negedge clk);
        clear_pulses();
    endtask

    // drives start (or boot) with a context; counts edges until done
    task automatic run_eval(input bit use_boot, input bit also_nmi, input logic [15:0] pc,
                            input logic [7:0] sp, input logic [7:0] st, input bit ip,
                            output int n);
        @(negedge clk);
        pc_in = pc; sp_in = sp; st_in = st; i_prev = ip;
        if (use_boot) boot = 1; else start = 1;
        nmi_set = also_nmi;
        n = 0;
        do begin
            @(negedge clk);
            clear_pulses();
            n++;
        end while (!done && n < 40);
    endtask

    task automatic t_reset_state();
        chk_eq("R1 pc_out", pc_out, 0);
        chk_eq("R1 sp_out", sp_out, 0);
        chk_eq("R1 st_out", st_out, 0);
        chk_eq("R1 flags busy/done/jammed", {busy, done, jammed}, 0);
        chk_eq("R1 kind/cycles", {entry_kind, entry_cycles}, 0);
    endtask

    task automatic t_empty_eval();
        int n, base;
        base = wn;
        run_eval(0, 0, 16'h4000, 8'hF0, 8'h00, 0, n);
        chk_eq("R1 no pending -> none", entry_kind, 0);
        chk_eq("R11 none latency", n, 1);
        chk_eq("R1 no writes", wn - base, 0);
    endtask

    task automatic t_boot();
        int n, base;
        pulse_misc(0, 0, 1);
        chk_eq("R6 jam_set raises jammed", jammed, 1);
        base = wn;
        run_eval(1, 0, 16'h1111, 8'h5A, 8'hFF, 1, n);
        chk_eq("R7 reset pc", pc_out, 16'h9ABC);
        chk_eq("R7 reset status", st_out, 8'h04);
        chk_eq("R7 reset sp kept", sp_out, 8'h5A);
        chk_eq("R7 reset kind/cycles", {entry_kind, entry_cycles}, {2'd1, 4'd0});
        chk_eq("R7 jam cleared", jammed, 0);
        chk_eq("R7 no writes", wn - base, 0);
        chk_eq("R11 reset latency", n, 3);
    endtask

    task automatic t_boot_over_start();
        int n;
        pulse_misc(1, 0, 0);
        @(negedge clk);
        pc_in = 16'h2222; sp_in = 8'h33; st_in = 8'h00; i_prev = 0;
        boot = 1; start = 1;
        n = 0;
        do begin @(negedge clk); clear_pulses(); n++; end while (!done && n < 40);
        chk_eq("R7 boot wins over start", entry_kind, 1);
        // NMI must survive since the start was not evaluated
        run_eval(0, 0, 16'h2222, 8'h33, 8'h00, 0, n);
        chk_eq("R7 start ignored, NMI still pending", entry_kind, 2);
    endtask

    task automatic t_nmi_masked_flag();
        int n, base;
        pulse_misc(1, 0, 0);
        base = wn;
        run_eval(0, 0, 16'h8123, 8'hFD, 8'hD3, 1, n);
        chk_eq("R4 NMI ignores i_prev", entry_kind, 2);
        chk_eq("R2 push count", wn - base, 3);
        chk_eq("R2 push hi", {wa[base], wd[base]}, {16'h01FD, 8'h81});
        chk_eq("R2 push lo", {wa[base+1], wd[base+1]}, {16'h01FC, 8'h23});
        chk_eq("R2 push status", {wa[base+2], wd[base+2]}, {16'h01FB, 8'hE3});
        chk_eq("R2 nmi pc", pc_out, 16'h1234);
        chk_eq("R2 nmi status", st_out, 8'hC3);
        chk_eq("R2 nmi sp", sp_out, 8'hFA);
        chk_eq("R2 nmi cycles", entry_cycles, 7);
        chk_eq("R11 entry latency", n, 6);
    endtask

    task automatic t_priority();
        int n, base;
        pulse_src(4'b0001, 4'b0000);
        pulse_misc(1, 0, 0);
        run_eval(0, 0, 16'hA000, 8'hFF, 8'h00, 0, n);
        chk_eq("R4 NMI before IRQ", entry_kind, 2);
        base = wn;
        run_eval(0, 0, 16'hA0F0, 8'hFF, 8'h00, 0, n);
        chk_eq("R3 level IRQ taken", entry_kind, 3);
        chk_eq("R3 irq pc", pc_out, 16'h5678);
        chk_eq("R3 irq status", st_out, 8'h04);
        chk_eq("R3 irq pushed status", wd[base+2], 8'h20);
        chk_eq("R3 irq cycles", entry_cycles, 7);
        pulse_src(4'b0000, 4'b0001);
    endtask

    task automatic t_mask();
        int n, base;
        pulse_src(4'b0010, 4'b0000);
        base = wn;
        run_eval(0, 0, 16'hC001, 8'h80, 8'h14, 1, n);
        chk_eq("R5 masked -> none", entry_kind, 0);
        chk_eq("R5 passthrough", {pc_out, sp_out, st_out}, {16'hC001, 8'h80, 8'h14});
        chk_eq("R5 no writes", wn - base, 0);
        run_eval(0, 0, 16'hC001, 8'h80, 8'h14, 0, n);
        chk_eq("R5 level persists then taken", entry_kind, 3);
        pulse_src(4'b0100, 4'b0010);
        run_eval(0, 0, 16'hC002, 8'h80, 8'h00, 0, n);
        chk_eq("R12 other source still taken", entry_kind, 3);
        pulse_src(4'b0000, 4'b0100);
        run_eval(0, 0, 16'hC003, 8'h80, 8'h00, 0, n);
        chk_eq("R12 all cleared -> none", entry_kind, 0);
    endtask

    task automatic t_oneshot();
        int n;
        pulse_misc(0, 1, 0);
        run_eval(0, 0, 16'hD000, 8'h80, 8'h00, 1, n);
        chk_eq("R8 masked temp -> none", entry_kind, 0);
        run_eval(0, 0, 16'hD000, 8'h80, 8'h00, 0, n);
        chk_eq("R8 temp dropped by evaluation", entry_kind, 0);
        pulse_misc(1, 0, 1);
        run_eval(0, 0, 16'hD000, 8'h80, 8'h00, 0, n);
        chk_eq("R6 jammed blocks NMI", entry_kind, 0);
        run_eval(1, 0, 16'hD000, 8'h80, 8'h00, 0, n);
        run_eval(0, 0, 16'hD000, 8'h80, 8'h00, 0, n);
        chk_eq("R8 NMI dropped while jammed", entry_kind, 0);
    endtask

    task automatic t_collide();
        int n;
        run_eval(0, 1, 16'hE000, 8'h80, 8'h00, 0, n);
        chk_eq("R9 same-cycle NMI not yet seen", entry_kind, 0);
        run_eval(0, 0, 16'hE000, 8'h80, 8'h00, 0, n);
        chk_eq("R9 set beat evaluation drop", entry_kind, 2);
        pulse_src(4'b1000, 4'b1000);
        run_eval(0, 0, 16'hE000, 8'h80, 8'h00, 0, n);
        chk_eq("R9 set beats clear", entry_kind, 3);
        pulse_src(4'b0000, 4'b1000);
    endtask

    task automatic t_wrap();
        int n, base;
        pulse_misc(1, 0, 0);
        base = wn;
        run_eval(0, 0, 16'h3456, 8'h00, 8'h00, 0, n);
        chk_eq("R10 first push", wa[base], 16'h0100);
        chk_eq("R10 second push", wa[base+1], 16'h01FF);
        chk_eq("R10 third push", wa[base+2], 16'h01FE);
        chk_eq("R10 sp_out", sp_out, 8'hFD);
    endtask

    task automatic t_busy_start();
        int n, base, extra;
        pulse_misc(1, 0, 0);
        base = wn;
        @(negedge clk);
        pc_in = 16'h7777; sp_in = 8'hF0; st_in = 8'h00; i_prev = 0; start = 1;
        @(negedge clk);
        clear_pulses();
        pc_in = 16'h9999; start = 1;
        n = 1;
        do begin @(negedge clk); clear_pulses(); n++; end while (!done && n < 40);
        chk_eq("R11 busy latency", n, 6);
        chk_eq("R11 one entry only", wn - base, 3);
        chk_eq("R11 first caller pushed", {wd[base], wd[base+1]}, 16'h7777);
        extra = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) extra++; end
        chk_eq("R11 no second done", extra, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog: actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_pulses();
        rst = 1; i_prev = 0; pc_in = '0; sp_in = '0; st_in = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset_state();
        t_empty_eval();
        t_boot();
        t_boot_over_start();
        t_nmi_masked_flag();
        t_priority();
        t_mask();
        t_oneshot();
        t_collide();
        t_wrap();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule